// File: doc/BRIEF.md
# Reloading Prescaled Event Counter

This block pairs a down-counter with an event counter, both 32 bits wide. Both advance on a prescale tick enable that arrives from outside at a nominal 20 MHz rate. While the down-counter is nonzero, each tick lowers it by one. The tick after it has reached zero reloads it from a programmable reload register, and on that same tick the event counter advances by one. With a reload value of N, the event counter therefore steps once every N+1 ticks.

Software drives the block through three independent write strobes, each with its own data word. These cover the reload register, the down-counter and the event counter. All three registers are always visible on read outputs. Address decoding and generation of the tick enable are left to the surrounding logic.

Top module: `tick_event_counter`

## Requirements
- R1: A synchronous active-high reset clears the reload register, the down-counter and the event counter to zero.
- R2: On a tick, a nonzero down-counter decrements by one. Without a tick, the down-counter and the event counter hold their values.
- R3: On a tick while the down-counter is zero, the down-counter takes the reload value and the event counter increments on that same tick. With reload 5 and start 7, the down-counter runs 7,6,5,4,3,2,1,0,5,4,3,2,1,0,5, and the event counter rises at each of the two reloads.
- R4: With a reload value of zero, the down-counter stays at zero and the event counter increments on every tick.
- R5: Writing the reload register leaves the current down-counter value unchanged. The new value takes effect at the next reload.
- R6: A down-counter write loads the data directly and overrides a tick in that cycle. If the down-counter was zero on that tick, the event counter still increments.
- R7: An event-counter write loads the data directly and overrides an increment in that cycle.
- R8: The event counter wraps from 0xFFFFFFFF to 0 and raises no flag.
- R9: Each read output shows its register's value from the clock edge after the update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Prescale tick enable, one cycle per tick |
| reload_we | input | 1 | Write strobe for the reload register |
| reload_wdata | input | 32 | Data for the reload register |
| down_we | input | 1 | Write strobe for the down-counter |
| down_wdata | input | 32 | Data for the down-counter |
| evt_we | input | 1 | Write strobe for the event counter |
| evt_wdata | input | 32 | Data for the event counter |
| reload_rd | output | 32 | Current reload value |
| down_rd | output | 32 | Current down-counter value |
| evt_rd | output | 32 | Current event counter value |

## Verification
All state is mapped directly to the read outputs, so a wrong value shows up one cycle after the faulty update. A misplaced reload point, such as reloading at one instead of zero, changes the period. That error shows on down_rd within a single tick, and on evt_rd when the increment lands on the wrong tick. A fault in write priority or in reload-value capture shows up at the next reload. The directed sequence therefore covers write-on-tick collisions, a zero reload and event-counter wrap.

// File: rtl/tec_pkg.sv
package tec_pkg;
    localparam int DEF_W = 32;

    typedef enum logic [1:0] {
        ACT_HOLD,
        ACT_DEC,
        ACT_RELOAD,
        ACT_LOAD
    } down_act_e;

    // Software write wins; otherwise a tick decrements or reloads.
    function automatic down_act_e pick_down_act(input logic we,
                                                input logic tick,
                                                input logic at_zero);
        if (we)
            return ACT_LOAD;
        else if (tick && at_zero)
            return ACT_RELOAD;
        else if (tick)
            return ACT_DEC;
        else
            return ACT_HOLD;
    endfunction
endpackage

// File: rtl/tec_reload_reg.sv
module tec_reload_reg #(
    parameter int W = tec_pkg::DEF_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         we,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] val
);
    always_ff @(posedge clk) begin
        if (rst)
            val <= '0;
        else if (we)
            val <= wdata;
    end

    assert_hold_R5: assert property (@(posedge clk) disable iff (rst)
        !we |=> $stable(val));
    assert_load_R5: assert property (@(posedge clk) disable iff (rst)
        we |=> val == $past(wdata));
endmodule

// File: rtl/tec_down_counter.sv
module tec_down_counter
    import tec_pkg::*;
#(
    parameter int W = DEF_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  logic         we,
    input  logic [W-1:0] wdata,
    input  logic [W-1:0] reload_val,
    output logic [W-1:0] cnt,
    output logic         wrap
);
    localparam logic [W-1:0] ONE = W'(1);

    logic      at_zero;
    down_act_e act;

    assign at_zero = (cnt == '0);
    assign wrap    = tick && at_zero;
    assign act     = pick_down_act(we, tick, at_zero);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else begin
            unique case (act)
                ACT_LOAD:   cnt <= wdata;
                ACT_RELOAD: cnt <= reload_val;
                ACT_DEC:    cnt <= cnt - ONE;
                default:    cnt <= cnt;
            endcase
        end
    end

    assert_dec_R2: assert property (@(posedge clk) disable iff (rst)
        (tick && !we && cnt != '0) |=> cnt == $past(cnt) - ONE);
    assert_idle_R2: assert property (@(posedge clk) disable iff (rst)
        (!tick && !we) |=> $stable(cnt));
    assert_reload_R3: assert property (@(posedge clk) disable iff (rst)
        (tick && !we && cnt == '0) |=> cnt == $past(reload_val));
    assert_wr_R6: assert property (@(posedge clk) disable iff (rst)
        we |=> cnt == $past(wdata));
endmodule

// File: rtl/tec_event_counter.sv
module tec_event_counter #(
    parameter int W = tec_pkg::DEF_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         inc,
    input  logic         we,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] cnt
);
    localparam logic [W-1:0] ONE = W'(1);

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (we)
            cnt <= wdata;
        else if (inc)
            cnt <= cnt + ONE;
    end

    assert_inc_R3: assert property (@(posedge clk) disable iff (rst)
        (inc && !we) |=> cnt == $past(cnt) + ONE);
    assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (!inc && !we) |=> $stable(cnt));
    assert_wr_R7: assert property (@(posedge clk) disable iff (rst)
        we |=> cnt == $past(wdata));
endmodule

// File: rtl/tick_event_counter.sv
module tick_event_counter #(
    parameter int WIDTH = tec_pkg::DEF_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_en,
    input  logic             reload_we,
    input  logic [WIDTH-1:0] reload_wdata,
    input  logic             down_we,
    input  logic [WIDTH-1:0] down_wdata,
    input  logic             evt_we,
    input  logic [WIDTH-1:0] evt_wdata,
    output logic [WIDTH-1:0] reload_rd,
    output logic [WIDTH-1:0] down_rd,
    output logic [WIDTH-1:0] evt_rd
);
    logic [WIDTH-1:0] reload_q;
    logic [WIDTH-1:0] down_q;
    logic [WIDTH-1:0] evt_q;
    logic             wrap;

    tec_reload_reg #(.W(WIDTH)) u_reload (
        .clk(clk), .rst(rst), .we(reload_we), .wdata(reload_wdata),
        .val(reload_q)
    );

    tec_down_counter #(.W(WIDTH)) u_down (
        .clk(clk), .rst(rst), .tick(tick_en), .we(down_we),
        .wdata(down_wdata), .reload_val(reload_q), .cnt(down_q), .wrap(wrap)
    );

    tec_event_counter #(.W(WIDTH)) u_evt (
        .clk(clk), .rst(rst), .inc(wrap), .we(evt_we), .wdata(evt_wdata),
        .cnt(evt_q)
    );

    assign reload_rd = reload_q;
    assign down_rd   = down_q;
    assign evt_rd    = evt_q;

    assert_zero_reload_R4: assert property (@(posedge clk) disable iff (rst)
        (tick_en && !down_we && reload_q == '0 && down_q == '0) |=> down_q == '0);
    assert_reset_R1: assert property (@(posedge clk)
        rst |=> (reload_rd == '0 && down_rd == '0 && evt_rd == '0));
endmodule

// File: tb/tick_event_counter_test.sv
module tick_event_counter_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick_en = 1'b0;
    logic        reload_we = 1'b0, down_we = 1'b0, evt_we = 1'b0;
    logic [31:0] reload_wdata = '0, down_wdata = '0, evt_wdata = '0;
    logic [31:0] reload_rd, down_rd, evt_rd;
    int          total = 0;
    int          fails = 0;

    always #10 clk = ~clk;

    tick_event_counter uut (
        .clk(clk), .rst(rst), .tick_en(tick_en),
        .reload_we(reload_we), .reload_wdata(reload_wdata),
        .down_we(down_we), .down_wdata(down_wdata),
        .evt_we(evt_we), .evt_wdata(evt_wdata),
        .reload_rd(reload_rd), .down_rd(down_rd), .evt_rd(evt_rd)
    );

    task automatic cyc();
        @(posedge clk);
        #1;
        reload_we = 1'b0;
        down_we   = 1'b0;
        evt_we    = 1'b0;
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic load_all(input logic [31:0] r, input logic [31:0] d, input logic [31:0] e);
        tick_en = 1'b0;
        reload_we = 1'b1; reload_wdata = r;
        down_we = 1'b1;   down_wdata = d;
        evt_we = 1'b1;    evt_wdata = e;
        cyc();
        chk("R9 reload", reload_rd, r);
        chk("R6 down", down_rd, d);
        chk("R7 evt", evt_rd, e);
    endtask

    task automatic t_reset();
        chk("R1 reload", reload_rd, 32'd0);
        chk("R1 down", down_rd, 32'd0);
        chk("R1 evt", evt_rd, 32'd0);
    endtask

    task automatic t_sequence();
        logic [31:0] seq [15] = '{7, 6, 5, 4, 3, 2, 1, 0, 5, 4, 3, 2, 1, 0, 5};
        load_all(32'd5, 32'd7, 32'd0);
        tick_en = 1'b1;
        for (int k = 1; k < 15; k++) begin
            cyc();
            chk("R3 down seq", down_rd, seq[k]);
            chk("R3 evt seq", evt_rd, (k >= 14) ? 32'd2 : (k >= 8) ? 32'd1 : 32'd0);
        end
        tick_en = 1'b0;
        for (int k = 0; k < 3; k++) cyc();
        chk("R2 hold down", down_rd, 32'd5);
        chk("R2 hold evt", evt_rd, 32'd2);
    endtask

    task automatic t_zero_reload();
        load_all(32'd0, 32'd0, 32'd10);
        tick_en = 1'b1;
        for (int k = 1; k <= 3; k++) begin
            cyc();
            chk("R4 down", down_rd, 32'd0);
            chk("R4 evt", evt_rd, 32'd10 + k);
        end
        tick_en = 1'b0;
    endtask

    task automatic t_reload_write();
        load_all(32'd5, 32'd3, 32'd0);
        reload_we = 1'b1; reload_wdata = 32'd9;
        cyc();
        chk("R5 down unchanged", down_rd, 32'd3);
        reload_we = 1'b1; reload_wdata = 32'd11; tick_en = 1'b1;
        cyc();
        chk("R5 down on tick", down_rd, 32'd2);
        cyc(); cyc();
        chk("R5 down zero", down_rd, 32'd0);
        cyc();
        chk("R5 new reload", down_rd, 32'd11);
        chk("R5 evt", evt_rd, 32'd1);
        tick_en = 1'b0;
    endtask

    task automatic t_down_collide();
        load_all(32'd4, 32'd0, 32'd0);
        tick_en = 1'b1; down_we = 1'b1; down_wdata = 32'd20;
        cyc();
        tick_en = 1'b0;
        chk("R6 write wins", down_rd, 32'd20);
        chk("R6 evt still counts", evt_rd, 32'd1);
    endtask

    task automatic t_evt_collide();
        load_all(32'd2, 32'd0, 32'd0);
        tick_en = 1'b1; evt_we = 1'b1; evt_wdata = 32'd100;
        cyc();
        tick_en = 1'b0;
        chk("R7 write wins", evt_rd, 32'd100);
        chk("R7 down reloads", down_rd, 32'd2);
    endtask

    task automatic t_wrap();
        load_all(32'd0, 32'd0, 32'hFFFF_FFFF);
        tick_en = 1'b1;
        cyc();
        tick_en = 1'b0;
        chk("R8 wrap", evt_rd, 32'd0);
    endtask

    initial begin
        #4_000_000;
        total++;
        fails++;
        $display("FAIL watchdog: actual running expected done");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        cyc(); cyc(); cyc();
        t_reset();
        rst = 1'b0;
        cyc();
        t_reset();
        t_sequence();
        t_zero_reload();
        t_reload_write();
        t_down_collide();
        t_evt_collide();
        t_wrap();
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule